// File: doc/BRIEF.md
# Two-Road Intersection Light Controller with Central Arbitration

This block runs the lights of a crossing where a main road (north-south) meets a side road (east-west). The two roads are driven by two small state machines in a fixed master and slave relationship. The main-road machine is the master. It holds the right of way by default and owns the one counter that times every green phase. The side-road machine is the slave. It cannot show green on its own: it asks for the right of way and waits for the master's grant.

The side road asks when its vehicle sensor reports a waiting car. The master answers only at the moment it takes the main road from green to yellow. After the main road reaches red, the side road turns green. The master alone decides when the side road has to give the right of way back. It decides this from the emergency input, from the side-road sensor, and from the shared timer. The side road then runs its own yellow phase, returns to red and signals the release, and the master resumes green.

The request, grant, return-to-red and release signals are brought out as ports so that they can be observed.

Top module: `xing_light_ctrl`

## Requirements
- R1: The two roads never show green in the same cycle. Each light is encoded as 2'b00 red, 2'b01 green and 2'b10 yellow.
- R2: The value 2'b11 never appears on either light output.
- R3: While the synchronous reset is high, the outputs are as follows: main road green, side road red, request, grant, return-to-red and release all low.
- R4: The side road goes red to green only on an edge where the grant was high and the main road was red. The request rises on the edge after a cycle in which the side road is red and its sensor is high. The request then stays high until the side road returns to red.
- R5: The grant rises only on the main road's green-to-yellow edge. It stays high until the side road shows green, and falls on the following edge.
- R6: The main road leaves green only when the request is high and it has been green for at least NS_MIN_GREEN cycles. Its yellow lasts exactly NS_AMBER cycles, and it is then red. It stays red until it sees a release pulse, and it is green on the next edge.
- R7: The return-to-red output is high exactly when the side road is green and at least one of these holds: the emergency input is high, the sensor is low, or the shared timer shows the side road has been green for MAX_GREEN cycles. On the next edge the side road turns yellow, so a side-road green lasts at most MAX_GREEN cycles.
- R8: The side-road yellow lasts exactly EW_AMBER cycles. On the edge where it turns red, the request drops and the release output pulses high for one cycle.
- R9: One counter times both roads' greens. It restarts at the onset of each green, so under a steady side-road demand the main-road green lasts exactly NS_MIN_GREEN cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ew_sense | input | 1 | Side-road vehicle sensor, high when a car waits |
| emerg | input | 1 | Emergency sensor, high forces the side road off green |
| ns_light | output | 2 | Main-road light code |
| ew_light | output | 2 | Side-road light code |
| ew_req | output | 1 | Side-road right-of-way request |
| ew_grant | output | 1 | Master grant to the side road |
| ew_to_red | output | 1 | Master command for the side road to leave green |
| ew_release | output | 1 | One-cycle pulse when the side road is back at red |

## Verification
The bench sweeps sensor and emergency patterns against a cycle model of its own. It checks every light, handshake and command signal every cycle, so a grant given early, for example during the main-road yellow, or a side-road green that starts before the main road is red, shows up at once as a mismatch and as a both-green violation.

Under steady demand it measures the length of every green run. A timer that is not cleared at the start of a green, or an off-by-one at MAX_GREEN, shows up as a run one cycle too long or too short.

It also covers an emergency pulse of a single cycle during a side-road green, and a sensor that drops while the grant is pending. A design that latched the command late, or that needed the sensor to enter green, would drift from the model there.

// File: rtl/xing_pkg.sv
package xing_pkg;

  typedef enum logic [1:0] {
    LT_RED    = 2'b00,
    LT_GREEN  = 2'b01,
    LT_YELLOW = 2'b10
  } lamp_t;

  // Decision to revoke the side road's right of way.
  function automatic logic revoke_due(input logic emg, input logic occupied,
                                      input int unsigned age, input int unsigned limit);
    return emg || !occupied || (age + 1 >= limit);
  endfunction

  // Main road may yield once it has been green long enough.
  function automatic logic min_green_met(input int unsigned age, input int unsigned min_len);
    return (age + 1 >= min_len);
  endfunction

  // Terminal count of a fixed-length phase.
  function automatic logic phase_last(input int unsigned age, input int unsigned len);
    return (age + 1 == len);
  endfunction

endpackage

// File: rtl/xing_master.sv
module xing_master
  import xing_pkg::*;
#(
  parameter int MAX_GREEN    = 16,
  parameter int NS_MIN_GREEN = 4,
  parameter int NS_AMBER     = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ew_req,
  input  logic  ew_release,
  input  logic  emerg,
  input  logic  ew_sense,
  input  lamp_t ew_lamp,
  output lamp_t ns_lamp,
  output logic  grant,
  output logic  to_red
);
  localparam int TMAX = (MAX_GREEN > NS_MIN_GREEN) ? MAX_GREEN : NS_MIN_GREEN;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int AW   = (NS_AMBER > 1) ? $clog2(NS_AMBER) : 1;

  logic [TW-1:0] green_age;
  logic [AW-1:0] amber_age;
  logic          any_green;
  logic          ns_yield;
  logic          amber_done;

  assign any_green  = (ns_lamp == LT_GREEN) || (ew_lamp == LT_GREEN);
  assign ns_yield   = (ns_lamp == LT_GREEN) && ew_req &&
                      min_green_met(32'(green_age), NS_MIN_GREEN);
  assign amber_done = (ns_lamp == LT_YELLOW) && phase_last(32'(amber_age), NS_AMBER);
  assign to_red     = (ew_lamp == LT_GREEN) &&
                      revoke_due(emerg, ew_sense, 32'(green_age), MAX_GREEN);

  // Shared green timer: restarts whenever neither road is green.
  always_ff @(posedge clk) begin
    if (rst) begin
      green_age <= '0;
    end else if (!any_green) begin
      green_age <= '0;
    end else if (!(&green_age)) begin
      green_age <= green_age + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_lamp   <= LT_GREEN;
      amber_age <= '0;
    end else begin
      unique case (ns_lamp)
        LT_GREEN: if (ns_yield) begin
          ns_lamp   <= LT_YELLOW;
          amber_age <= '0;
        end
        LT_YELLOW: if (amber_done) ns_lamp <= LT_RED;
                   else            amber_age <= amber_age + 1'b1;
        LT_RED: if (ew_release) ns_lamp <= LT_GREEN;
        default: ns_lamp <= LT_RED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     grant <= 1'b0;
    else if (ns_yield)           grant <= 1'b1;
    else if (ew_lamp == LT_GREEN) grant <= 1'b0;
  end

  // R5
  grant_on_yield_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> (ns_lamp == LT_YELLOW && $past(ns_lamp) == LT_GREEN));
  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && ew_lamp != LT_GREEN) |=> grant);
  // R6
  ns_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_lamp == LT_RED && !ew_release) |=> (ns_lamp != LT_GREEN));
  // R2
  ns_code_chk: assert property (@(posedge clk) disable iff (rst)
    ns_lamp != 2'b11);
endmodule

// File: rtl/xing_slave.sv
module xing_slave
  import xing_pkg::*;
#(
  parameter int EW_AMBER = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ew_sense,
  input  logic  grant,
  input  lamp_t ns_lamp,
  input  logic  to_red,
  output lamp_t ew_lamp,
  output logic  req,
  output logic  release_p
);
  localparam int AW = (EW_AMBER > 1) ? $clog2(EW_AMBER) : 1;

  logic [AW-1:0] amber_age;
  logic          may_enter;
  logic          amber_done;

  assign may_enter  = grant && (ns_lamp == LT_RED);
  assign amber_done = (ew_lamp == LT_YELLOW) && phase_last(32'(amber_age), EW_AMBER);

  always_ff @(posedge clk) begin
    if (rst) begin
      ew_lamp   <= LT_RED;
      amber_age <= '0;
      req       <= 1'b0;
      release_p <= 1'b0;
    end else begin
      release_p <= 1'b0;
      unique case (ew_lamp)
        LT_RED: begin
          if (ew_sense) req <= 1'b1;
          if (may_enter) ew_lamp <= LT_GREEN;
        end
        LT_GREEN: if (to_red) begin
          ew_lamp   <= LT_YELLOW;
          amber_age <= '0;
        end
        LT_YELLOW: if (amber_done) begin
          ew_lamp   <= LT_RED;
          req       <= 1'b0;
          release_p <= 1'b1;
        end else begin
          amber_age <= amber_age + 1'b1;
        end
        default: ew_lamp <= LT_RED;
      endcase
    end
  end

  // R4
  ew_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == LT_GREEN && $past(ew_lamp) == LT_RED) |->
      ($past(grant) && $past(ns_lamp) == LT_RED));
  // R7
  revoke_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == LT_GREEN && to_red) |=> (ew_lamp == LT_YELLOW));
  // R8
  release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (ew_lamp == LT_RED && $past(ew_lamp) == LT_YELLOW) |-> (release_p && !req));
  // R2
  ew_code_chk: assert property (@(posedge clk) disable iff (rst)
    ew_lamp != 2'b11);
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
  import xing_pkg::*;
#(
  parameter int MAX_GREEN    = 16,
  parameter int NS_MIN_GREEN = 4,
  parameter int NS_AMBER     = 3,
  parameter int EW_AMBER     = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ew_sense,
  input  logic       emerg,
  output logic [1:0] ns_light,
  output logic [1:0] ew_light,
  output logic       ew_req,
  output logic       ew_grant,
  output logic       ew_to_red,
  output logic       ew_release
);
  lamp_t ns_lamp;
  lamp_t ew_lamp;

  xing_master #(
    .MAX_GREEN   (MAX_GREEN),
    .NS_MIN_GREEN(NS_MIN_GREEN),
    .NS_AMBER    (NS_AMBER)
  ) u_master (
    .clk       (clk),
    .rst       (rst),
    .ew_req    (ew_req),
    .ew_release(ew_release),
    .emerg     (emerg),
    .ew_sense  (ew_sense),
    .ew_lamp   (ew_lamp),
    .ns_lamp   (ns_lamp),
    .grant     (ew_grant),
    .to_red    (ew_to_red)
  );

  xing_slave #(
    .EW_AMBER(EW_AMBER)
  ) u_slave (
    .clk      (clk),
    .rst      (rst),
    .ew_sense (ew_sense),
    .grant    (ew_grant),
    .ns_lamp  (ns_lamp),
    .to_red   (ew_to_red),
    .ew_lamp  (ew_lamp),
    .req      (ew_req),
    .release_p(ew_release)
  );

  assign ns_light = ns_lamp;
  assign ew_light = ew_lamp;

  // R1
  never_both_green_chk: assert property (@(posedge clk) disable iff (rst)
    !(ns_light == 2'b01 && ew_light == 2'b01));
endmodule

// File: tb/xing_light_ctrl_tb.sv
`timescale 1ns/1ps
module xing_light_ctrl_tb;
  localparam int MG   = 6;
  localparam int NMIN = 3;
  localparam int NAMB = 2;
  localparam int EAMB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic se  = 1'b0;
  logic em  = 1'b0;
  logic [1:0] ns_light, ew_light;
  logic req, grant, to_red, rel;

  always #2 clk = ~clk;

  xing_light_ctrl #(.MAX_GREEN(MG), .NS_MIN_GREEN(NMIN), .NS_AMBER(NAMB), .EW_AMBER(EAMB)) u_dut (
    .clk(clk), .rst(rst), .ew_sense(se), .emerg(em),
    .ns_light(ns_light), .ew_light(ew_light), .ew_req(req),
    .ew_grant(grant), .ew_to_red(to_red), .ew_release(rel));

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model. Phase codes: 0 red, 1 green, 2 yellow.
  int m_ns = 1, m_ew = 0, m_age = 0, m_nsy = 0, m_ewy = 0;
  bit m_g = 0, m_r = 0, m_d = 0;

  function automatic bit m_revoke();
    return (m_ew == 1) && (em || !se || m_age >= MG - 1);
  endfunction

  always @(posedge clk) begin
    int ns_n, ew_n, age_n, nsy_n, ewy_n;
    bit g_n, r_n, d_n, yield;
    if (rst) begin
      m_ns = 1; m_ew = 0; m_age = 0; m_nsy = 0; m_ewy = 0;
      m_g = 0; m_r = 0; m_d = 0;
    end else begin
      ns_n = m_ns; ew_n = m_ew; nsy_n = m_nsy; ewy_n = m_ewy;
      g_n = m_g; r_n = m_r; d_n = 0;
      yield = (m_ns == 1) && m_r && (m_age >= NMIN - 1);
      age_n = (m_ns == 1 || m_ew == 1) ? m_age + 1 : 0;
      if (yield) begin ns_n = 2; nsy_n = 0; end
      else if (m_ns == 2) begin
        if (m_nsy == NAMB - 1) ns_n = 0; else nsy_n = m_nsy + 1;
      end else if (m_ns == 0 && m_d) ns_n = 1;
      if (yield) g_n = 1; else if (m_ew == 1) g_n = 0;
      case (m_ew)
        0: begin
          if (se) r_n = 1;
          if (m_g && m_ns == 0) ew_n = 1;
        end
        1: if (m_revoke()) begin ew_n = 2; ewy_n = 0; end
        default: if (m_ewy == EAMB - 1) begin ew_n = 0; r_n = 0; d_n = 1; end
                 else ewy_n = m_ewy + 1;
      endcase
      m_ns = ns_n; m_ew = ew_n; m_age = age_n; m_nsy = nsy_n; m_ewy = ewy_n;
      m_g = g_n; m_r = r_n; m_d = d_n;
    end
  end

  // Green run measurement on the DUT outputs.
  int ew_run = 0, ns_run = 0, ew_last = -1, ns_last = -1;

  task automatic compare();
    chk(!(ns_light == 2'b01 && ew_light == 2'b01), "R1 both green", ns_light, ew_light);
    chk(ns_light != 2'b11 && ew_light != 2'b11, "R2 illegal code", {ns_light, ew_light}, 0);
    chk(int'(ns_light) == m_ns, "R6 ns light", ns_light, m_ns);
    chk(int'(ew_light) == m_ew, "R4 ew light", ew_light, m_ew);
    chk(grant == m_g, "R5 grant", grant, m_g);
    chk(req == m_r, "R4 request", req, m_r);
    chk(rel == m_d, "R8 release", rel, m_d);
    chk(to_red == m_revoke(), "R7 to-red", to_red, m_revoke());
    ew_last = -1; ns_last = -1;
    if (ew_light == 2'b01) ew_run++;
    else if (ew_run > 0) begin ew_last = ew_run; ew_run = 0; end
    if (ns_light == 2'b01) ns_run++;
    else if (ns_run > 0) begin ns_last = ns_run; ns_run = 0; end
  endtask

  task automatic step(input logic s, input logic e);
    @(negedge clk);
    compare();
    se = s; em = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int nsruns;
    // R3 reset state
    repeat (3) @(negedge clk);
    chk(ns_light == 2'b01, "R3 ns reset", ns_light, 1);
    chk(ew_light == 2'b00, "R3 ew reset", ew_light, 0);
    chk({req, grant, to_red, rel} == 4'b0, "R3 handshakes reset", {req, grant, to_red, rel}, 0);
    rst = 1'b0;

    // Steady demand: exact green lengths (R7 side road, R9 main road)
    nsruns = 0;
    for (int k = 0; k < 150; k++) begin
      step(1'b1, 1'b0);
      if (ew_last >= 0) chk(ew_last == MG, "R7 max green length", ew_last, MG);
      if (ns_last >= 0) begin
        if (nsruns > 0) chk(ns_last == NMIN, "R9 ns green length", ns_last, NMIN);
        nsruns++;
      end
    end

    // No demand: main road keeps green, no request (R4, R6)
    for (int k = 0; k < 40; k++) step(1'b0, 1'b0);
    chk(ns_light == 2'b01 && !req, "R4 idle keeps main green", {ns_light, req}, 2);

    // One-cycle emergency during a side-road green (R7)
    se = 1'b1;
    for (int k = 0; k < 60 && ew_light != 2'b01; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk(ew_light == 2'b10, "R7 emergency forces yellow", ew_light, 2);
    for (int k = 0; k < EAMB + 2; k++) step(1'b1, 1'b0);

    // Sensor drops while grant pending (R4, R5)
    for (int k = 0; k < 60 && grant != 1'b1; k++) step(1'b1, 1'b0);
    for (int k = 0; k < 20; k++) step(1'b0, 1'b0);

    // Sweep over sensor/emergency patterns (all requirements via model)
    for (int p = 0; p < 32; p++) begin
      for (int k = 0; k < 40; k++) begin
        step(p[k % 5], (k % 7 == 3) && p[0] && p[2]);
      end
    end

    step(1'b0, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule